// File: doc/BRIEF.md
# Read-Sequence RAM Write Overlay Controller

This controller sits between a host processor's read-only program memory bus and two memories: a boot ROM and a 128 KB SRAM overlay. The host has no write strobe. It stores bytes into the SRAM by issuing a fixed pattern of ordinary reads. The block decodes the 16-bit host address together with the active-low chip-select and output-enable. From these it generates separate chip-select and output-enable lines for each memory, an SRAM write-enable, and three upper SRAM address bits for banking.

A host cycle runs while both `cs_n_i` and `oe_n_i` are low. All internal registers advance when that cycle ends. The host writes one byte in three reads. It first reads the write-unlock address `CMD_WR_ADDR`. The low byte of the address of its next read is the data to store. Its third read addresses the target location. During that third cycle the block drives the held byte onto the data bus and pulses the SRAM write-enable. Reads inside two configuration pages set the mode and bank registers from the low address byte. Those registers choose between ROM and SRAM, turn echo mode on or off, set the bank size, and pick the write and read banks. Software can therefore load one bank while it executes from another.

Top module: `ovl_ctrl`

## Requirements
- R1: While `cs_n_i` or `oe_n_i` is high, all five memory strobes are high, `data_oe_o` is 0 and `data_o` is 0.
- R2: After reset the block serves normal reads from the ROM, echo is off, both bank numbers and the size code are zero, and no write sequence is in progress. A sequence that is partly done when reset arrives is discarded.
- R3: A normal read with ROM selected drives {rom_cs_n,rom_oe_n,ram_cs_n,ram_oe_n,ram_we_n} = 00111. With SRAM selected it drives 11001. The two output-enables are never low together.
- R4: Take three consecutive reads: first `CMD_WR_ADDR` (0x7FF0), then any address A, then any address T. The third cycle drives strobes 11010, sets `data_oe_o` to 1 and `data_o` to A[7:0], and maps `ram_ahi_o` with the write bank for T.
- R5: `data_oe_o` is 1 only during a write cycle (R4). The read after a completed write is an ordinary read.
- R6: If the read after the unlock read is `CMD_WR_ADDR` again or falls in either configuration page, the sequence is aborted. That read is an ordinary read, and the next two reads are ordinary reads as well.
- R7: A read in idle with address[15:8] = `MODE_PAGE` (0x7E) loads three fields from address[7:0]. Bit 0 selects SRAM (1) or ROM (0) for normal reads, bit 1 enables echo, and bits 3:2 give the size code (0 = 16 KB, 1 = 32 KB, 2 or 3 = 64 KB). The new setting applies from the next cycle. The loading read itself is served with the old setting.
- R8: A read in idle with address[15:8] = `BANK_PAGE` (0x7D) loads the write bank from address[2:0] and the read bank from address[5:3].
- R9: During a write, `ram_ahi_o` equals the write bank for 16 KB, {wbank[2:1], addr[14]} for 32 KB, and {wbank[2], addr[15:14]} for 64 KB.
- R10: During normal reads, `ram_ahi_o` uses the read bank with the same size rule as R9.
- R11: With echo on and ROM selected, a normal read drives strobes 00010, leaves `data_oe_o` at 0 and maps `ram_ahi_o` with the write bank.
- R12: A configuration-page read that comes outside idle changes no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock, faster than host cycles |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Host address bus |
| cs_n_i | input | 1 | Host chip-select, active low |
| oe_n_i | input | 1 | Host output-enable, active low |
| rom_cs_n_o | output | 1 | ROM chip-select, active low |
| rom_oe_n_o | output | 1 | ROM output-enable, active low |
| ram_cs_n_o | output | 1 | SRAM chip-select, active low |
| ram_oe_n_o | output | 1 | SRAM output-enable, active low |
| ram_we_n_o | output | 1 | SRAM write-enable, active low |
| ram_ahi_o | output | 3 | SRAM address bits 16:14 |
| data_o | output | 8 | Byte driven onto the data bus during a write |
| data_oe_o | output | 1 | Data bus driver enable |

## Verification
The bench aims at several sequence corner cases:
- An aborted unlock. A design that ignored the abort would treat a later ordinary read as a write target and corrupt the SRAM.
- A configuration read made in the middle of a sequence. If that read were accepted, the ROM/SRAM selection would flip without warning.
- A reset arriving halfway through a write. If the partial sequence survived, the first read after reset would become a write.

Further checks cover the read that follows a completed write, which a design with a stuck write state would keep writing into. Bank mapping is checked at every size, with host address bits 15:14 varied. A mix-up between the read bank and the write bank shows up there as wrong upper SRAM address bits. Echo reads are checked to enable the ROM and the SRAM together while the controller's own data driver stays off.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_ARM = 2'd1, ST_DATA = 2'd2} seq_e;

  // field positions inside the configuration byte
  localparam int MODE_SEL_BIT  = 0;
  localparam int MODE_ECHO_BIT = 1;
  localparam int MODE_SZ_LSB   = 2;
  localparam int BANK_WR_LSB   = 0;
  localparam int BANK_RD_LSB   = 3;
  localparam int SZW           = 2;
  localparam int BKW           = 3;

  function automatic logic [BKW-1:0] bank_map(input logic [SZW-1:0] sz,
                                              input logic [BKW-1:0] bank,
                                              input logic [1:0]     a_top);
    case (sz)
      2'd0:    bank_map = bank;
      2'd1:    bank_map = {bank[2:1], a_top[0]};
      default: bank_map = {bank[2], a_top};
    endcase
  endfunction
endpackage

// File: rtl/ovl_seq.sv
module ovl_seq
  import ovl_pkg::*;
#(
  parameter int AW          = 16,
  parameter int DW          = 8,
  parameter logic [AW-1:0] CMD_WR_ADDR = 16'h7FF0,
  parameter logic [AW-DW-1:0] MODE_PAGE = 8'h7E,
  parameter logic [AW-DW-1:0] BANK_PAGE = 8'h7D
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strobe_n_i,
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] addr_lo_o,
  output logic          cyc_end_o,
  output logic          wr_state_o,
  output logic          mode_hit_o,
  output logic          bank_hit_o
);
  localparam int PW = AW - DW;

  logic          strobe_q;
  logic [AW-1:0] addr_q;
  seq_e          st_q, st_d;
  logic [PW-1:0] page;
  logic          page_mode, page_bank, is_unlock;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b1;
      addr_q   <= '0;
      st_q     <= ST_IDLE;
    end else begin
      strobe_q <= strobe_n_i;
      if (!strobe_n_i) addr_q <= addr_i;
      st_q <= st_d;
    end
  end

  assign cyc_end_o = strobe_n_i & ~strobe_q;
  assign page      = addr_q[AW-1:DW];
  assign page_mode = (page == MODE_PAGE);
  assign page_bank = (page == BANK_PAGE);
  assign is_unlock = (addr_q == CMD_WR_ADDR);

  always_comb begin
    st_d = st_q;
    if (cyc_end_o) begin
      case (st_q)
        ST_IDLE: st_d = is_unlock ? ST_ARM : ST_IDLE;
        ST_ARM:  st_d = (is_unlock | page_mode | page_bank) ? ST_IDLE : ST_DATA;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  assign addr_lo_o  = addr_q[DW-1:0];
  assign wr_state_o = (st_q == ST_DATA);
  assign mode_hit_o = cyc_end_o & (st_q == ST_IDLE) & page_mode;
  assign bank_hit_o = cyc_end_o & (st_q == ST_IDLE) & page_bank;
endmodule

// File: rtl/ovl_cfg.sv
module ovl_cfg
  import ovl_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cyc_end_i,
  input  logic           wr_state_i,
  input  logic           mode_hit_i,
  input  logic           bank_hit_i,
  input  logic [DW-1:0]  addr_lo_i,
  output logic [DW-1:0]  hold_o,
  output logic           sel_ram_o,
  output logic           echo_o,
  output logic [SZW-1:0] size_o,
  output logic [BKW-1:0] wbank_o,
  output logic [BKW-1:0] rbank_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_o    <= '0;
      sel_ram_o <= 1'b0;
      echo_o    <= 1'b0;
      size_o    <= '0;
      wbank_o   <= '0;
      rbank_o   <= '0;
    end else begin
      // the write cycle itself must not overwrite the byte it stores
      if (cyc_end_i && !wr_state_i) hold_o <= addr_lo_i;
      if (mode_hit_i) begin
        sel_ram_o <= addr_lo_i[MODE_SEL_BIT];
        echo_o    <= addr_lo_i[MODE_ECHO_BIT];
        size_o    <= addr_lo_i[MODE_SZ_LSB +: SZW];
      end
      if (bank_hit_i) begin
        wbank_o <= addr_lo_i[BANK_WR_LSB +: BKW];
        rbank_o <= addr_lo_i[BANK_RD_LSB +: BKW];
      end
    end
  end
endmodule

// File: rtl/ovl_map.sv
module ovl_map
  import ovl_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic           strobe_n_i,
  input  logic           wr_state_i,
  input  logic           sel_ram_i,
  input  logic           echo_i,
  input  logic [SZW-1:0] size_i,
  input  logic [BKW-1:0] wbank_i,
  input  logic [BKW-1:0] rbank_i,
  input  logic [1:0]     a_top_i,
  input  logic [DW-1:0]  hold_i,
  output logic           rom_cs_n_o,
  output logic           rom_oe_n_o,
  output logic           ram_cs_n_o,
  output logic           ram_oe_n_o,
  output logic           ram_we_n_o,
  output logic [BKW-1:0] ram_ahi_o,
  output logic [DW-1:0]  data_o,
  output logic           data_oe_o
);
  logic use_wbank;

  always_comb begin
    rom_cs_n_o = 1'b1;
    rom_oe_n_o = 1'b1;
    ram_cs_n_o = 1'b1;
    ram_oe_n_o = 1'b1;
    ram_we_n_o = 1'b1;
    data_oe_o  = 1'b0;
    use_wbank  = 1'b0;
    if (!strobe_n_i) begin
      if (wr_state_i) begin
        ram_cs_n_o = 1'b0;
        ram_we_n_o = 1'b0;
        data_oe_o  = 1'b1;
        use_wbank  = 1'b1;
      end else if (sel_ram_i) begin
        ram_cs_n_o = 1'b0;
        ram_oe_n_o = 1'b0;
      end else begin
        rom_cs_n_o = 1'b0;
        rom_oe_n_o = 1'b0;
        if (echo_i) begin
          ram_cs_n_o = 1'b0;
          ram_we_n_o = 1'b0;
          use_wbank  = 1'b1;
        end
      end
    end
  end

  assign ram_ahi_o = bank_map(size_i, use_wbank ? wbank_i : rbank_i, a_top_i);
  assign data_o    = data_oe_o ? hold_i : '0;
endmodule

// File: rtl/ovl_ctrl.sv
module ovl_ctrl
  import ovl_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-1:0]    CMD_WR_ADDR = 16'h7FF0,
  parameter logic [AW-DW-1:0] MODE_PAGE   = 8'h7E,
  parameter logic [AW-DW-1:0] BANK_PAGE   = 8'h7D
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          cs_n_i,
  input  logic          oe_n_i,
  output logic          rom_cs_n_o,
  output logic          rom_oe_n_o,
  output logic          ram_cs_n_o,
  output logic          ram_oe_n_o,
  output logic          ram_we_n_o,
  output logic [2:0]    ram_ahi_o,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o
);
  logic           strobe_n;
  logic [DW-1:0]  addr_lo, hold;
  logic           cyc_end, wr_state, mode_hit, bank_hit;
  logic           sel_ram, echo;
  logic [SZW-1:0] size;
  logic [BKW-1:0] wbank, rbank;

  assign strobe_n = cs_n_i | oe_n_i;

  ovl_seq #(
    .AW(AW), .DW(DW), .CMD_WR_ADDR(CMD_WR_ADDR),
    .MODE_PAGE(MODE_PAGE), .BANK_PAGE(BANK_PAGE)
  ) u_seq (
    .clk_i, .rst_ni,
    .strobe_n_i(strobe_n), .addr_i,
    .addr_lo_o(addr_lo), .cyc_end_o(cyc_end), .wr_state_o(wr_state),
    .mode_hit_o(mode_hit), .bank_hit_o(bank_hit)
  );

  ovl_cfg #(.DW(DW)) u_cfg (
    .clk_i, .rst_ni,
    .cyc_end_i(cyc_end), .wr_state_i(wr_state),
    .mode_hit_i(mode_hit), .bank_hit_i(bank_hit), .addr_lo_i(addr_lo),
    .hold_o(hold), .sel_ram_o(sel_ram), .echo_o(echo), .size_o(size),
    .wbank_o(wbank), .rbank_o(rbank)
  );

  ovl_map #(.DW(DW)) u_map (
    .strobe_n_i(strobe_n), .wr_state_i(wr_state), .sel_ram_i(sel_ram),
    .echo_i(echo), .size_i(size), .wbank_i(wbank), .rbank_i(rbank),
    .a_top_i(addr_i[AW-1:AW-2]), .hold_i(hold),
    .rom_cs_n_o, .rom_oe_n_o, .ram_cs_n_o, .ram_oe_n_o, .ram_we_n_o,
    .ram_ahi_o, .data_o, .data_oe_o
  );
endmodule

// File: rtl/ovl_ctrl_chk.sv
module ovl_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_n_i,
  input logic          oe_n_i,
  input logic          rom_cs_n_o,
  input logic          rom_oe_n_o,
  input logic          ram_cs_n_o,
  input logic          ram_oe_n_o,
  input logic          ram_we_n_o,
  input logic [DW-1:0] data_o,
  input logic          data_oe_o
);
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_n_i | oe_n_i) |-> (rom_cs_n_o & rom_oe_n_o & ram_cs_n_o & ram_oe_n_o & ram_we_n_o & !data_oe_o));

  assert_no_dual_oe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rom_oe_n_o && !ram_oe_n_o));

  assert_we_no_ram_oe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_we_n_o |-> ram_oe_n_o);

  assert_drive_only_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (!ram_we_n_o && !ram_cs_n_o && rom_cs_n_o && rom_oe_n_o));

  assert_quiet_bus_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> (data_o == '0));

  assert_echo_rom_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ram_we_n_o && !rom_cs_n_o) |-> (!rom_oe_n_o && !data_oe_o));
endmodule

bind ovl_ctrl ovl_ctrl_chk #(.DW(DW)) u_chk (
  .clk_i, .rst_ni, .cs_n_i, .oe_n_i,
  .rom_cs_n_o, .rom_oe_n_o, .ram_cs_n_o, .ram_oe_n_o, .ram_we_n_o,
  .data_o, .data_oe_o
);

// File: tb/tb_ovl_ctrl.sv
module tb_ovl_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic        cs_n_i = 1'b1;
  logic        oe_n_i = 1'b1;
  logic        rom_cs_n_o, rom_oe_n_o, ram_cs_n_o, ram_oe_n_o, ram_we_n_o;
  logic [2:0]  ram_ahi_o;
  logic [7:0]  data_o;
  logic        data_oe_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk_i = ~clk_i;

  ovl_ctrl dut (
    .clk_i, .rst_ni, .addr_i, .cs_n_i, .oe_n_i,
    .rom_cs_n_o, .rom_oe_n_o, .ram_cs_n_o, .ram_oe_n_o, .ram_we_n_o,
    .ram_ahi_o, .data_o, .data_oe_o
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [15:0] addr;
    logic [4:0]  ctl;   // rom_cs_n, rom_oe_n, ram_cs_n, ram_oe_n, ram_we_n
    logic        oe;
    logic [2:0]  ahi;
    logic [7:0]  dat;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{4'd3,  16'h1234, 5'b00111, 1'b0, 3'b000, 8'h00},  // R3 rom read
    '{4'd4,  16'h7FF0, 5'b00111, 1'b0, 3'b000, 8'h00},  // R4 unlock
    '{4'd4,  16'h00A5, 5'b00111, 1'b0, 3'b000, 8'h00},  // R4 data byte
    '{4'd4,  16'h2345, 5'b11010, 1'b1, 3'b000, 8'hA5},  // R4 write
    '{4'd5,  16'h2345, 5'b00111, 1'b0, 3'b000, 8'h00},  // R5 back to normal
    '{4'd7,  16'h7E05, 5'b00111, 1'b0, 3'b000, 8'h00},  // R7 sel ram, 32K
    '{4'd8,  16'h7D1E, 5'b11001, 1'b0, 3'b001, 8'h00},  // R8 wb=6 rb=3
    '{4'd10, 16'hC000, 5'b11001, 1'b0, 3'b011, 8'h00},  // R10
    '{4'd10, 16'h7FF0, 5'b11001, 1'b0, 3'b011, 8'h00},
    '{4'd10, 16'h005A, 5'b11001, 1'b0, 3'b010, 8'h00},
    '{4'd9,  16'h4000, 5'b11010, 1'b1, 3'b111, 8'h5A},  // R9 32K write
    '{4'd6,  16'h7FF0, 5'b11001, 1'b0, 3'b011, 8'h00},  // R6
    '{4'd6,  16'h7FF0, 5'b11001, 1'b0, 3'b011, 8'h00},  // R6 abort
    '{4'd6,  16'h0077, 5'b11001, 1'b0, 3'b010, 8'h00},
    '{4'd6,  16'h0000, 5'b11001, 1'b0, 3'b010, 8'h00},  // R6 no write
    '{4'd7,  16'h7E0A, 5'b11001, 1'b0, 3'b011, 8'h00},  // R7 rom, echo, 64K
    '{4'd11, 16'h8000, 5'b00010, 1'b0, 3'b110, 8'h00},  // R11 echo
    '{4'd11, 16'h4000, 5'b00010, 1'b0, 3'b101, 8'h00},
    '{4'd11, 16'h7FF0, 5'b00010, 1'b0, 3'b101, 8'h00},
    '{4'd11, 16'h0033, 5'b00010, 1'b0, 3'b100, 8'h00},
    '{4'd9,  16'h8123, 5'b11010, 1'b1, 3'b110, 8'h33}   // R9 64K write
  };

  function automatic logic [4:0] ctl_now();
    return {rom_cs_n_o, rom_oe_n_o, ram_cs_n_o, ram_oe_n_o, ram_we_n_o};
  endfunction

  task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one host read; outputs sampled mid-cycle
  task automatic host_read(input logic [15:0] a, output logic [16:0] obs);
    @(negedge clk_i);
    addr_i = a; cs_n_i = 1'b0; oe_n_i = 1'b0;
    repeat (2) @(negedge clk_i);
    obs = {ctl_now(), data_oe_o, ram_ahi_o, data_o};
    cs_n_i = 1'b1; oe_n_i = 1'b1;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    logic [16:0] obs;
    repeat (3) @(negedge clk_i);
    // R2/R1: outputs quiet in reset and after release
    check("R2 in reset", {ctl_now(), data_oe_o, 3'b000, data_o}, {5'b11111, 1'b0, 3'b000, 8'h00});
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R1 idle bus", {ctl_now(), data_oe_o, 3'b000, data_o}, {5'b11111, 1'b0, 3'b000, 8'h00});

    for (int i = 0; i < NV; i++) begin
      host_read(VEC[i].addr, obs);
      check($sformatf("R%0d vec%0d", VEC[i].req, i), obs,
            {VEC[i].ctl, VEC[i].oe, VEC[i].ahi, VEC[i].dat});
    end

    // R1: chip-select low with output-enable high is no cycle
    @(negedge clk_i);
    addr_i = 16'h1000; cs_n_i = 1'b0; oe_n_i = 1'b1;
    @(negedge clk_i);
    check("R1 cs only", {ctl_now(), data_oe_o, 3'b000, data_o}, {5'b11111, 1'b0, 3'b000, 8'h00});
    cs_n_i = 1'b1;

    // R2: fresh reset restores rom, 16K, bank 0
    do_reset();
    host_read(16'hC000, obs);
    check("R2 after reset", obs, {5'b00111, 1'b0, 3'b000, 8'h00});

    // R12: config read while armed is ignored and aborts
    host_read(16'h7FF0, obs);
    host_read(16'h7E01, obs);
    check("R12 cfg in arm read", obs, {5'b00111, 1'b0, 3'b000, 8'h00});
    host_read(16'h0000, obs);
    check("R12 sel unchanged", obs, {5'b00111, 1'b0, 3'b000, 8'h00});
    host_read(16'h0000, obs);
    check("R12 no write", obs, {5'b00111, 1'b0, 3'b000, 8'h00});

    // R7: same config from idle does take effect
    host_read(16'h7E01, obs);
    host_read(16'h0000, obs);
    check("R7 sel ram", obs, {5'b11001, 1'b0, 3'b000, 8'h00});

    // R2: reset during a sequence discards it
    host_read(16'h7FF0, obs);
    host_read(16'h00AA, obs);
    do_reset();
    host_read(16'h0100, obs);
    check("R2 seq dropped", obs, {5'b00111, 1'b0, 3'b000, 8'h00});

    // R8/R10 at 16K: read bank used directly
    host_read(16'h7D28, obs);   // rb=5 wb=0
    host_read(16'h7E01, obs);
    host_read(16'hC000, obs);
    check("R10 16K read bank", obs, {5'b11001, 1'b0, 3'b101, 8'h00});
    host_read(16'h7FF0, obs);
    host_read(16'h0011, obs);
    host_read(16'hC000, obs);
    check("R9 16K write bank", obs, {5'b11010, 1'b1, 3'b000, 8'h11});

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule